// File: doc/BRIEF.md
# Pixel Matrix Row Sequencer

This block drives the row control lines of a pixel sensor matrix that is read out one row at a time. Each row occupies one slot. In that slot the row's select line is raised first. After a programmable settle time a strobe asks the column front end to capture the signal-plus-pedestal current. The row's clear line is then pulsed for a programmable width. A second strobe follows a further settle time and captures the pedestal alone. Both samples fall inside the same slot, so the downstream logic can subtract them directly and no pedestal memory is needed.

A start pulse launches a frame at row 0. Rows advance in ascending order up to the programmed count. When the last row has finished, the next frame begins in the following cycle. A stop request lets the current frame finish and then parks the block, with every line low. The row count and the three phase lengths are captured when a frame begins. Changes to them therefore take effect at the next frame boundary and never part of the way through a frame.

Top module: `pixrow_seq`

## Requirements
- R1: After reset, and whenever the block is idle, every select and clear line is low, both strobes, `row_valid` and `frame_done` are low, and `row_idx` is 0.
- R2: A `start` pulse seen while idle makes row 0's select line (bit 0 of `gate_row`) high in the very next cycle. A `start` pulse seen while a frame is running has no effect on any output.
- R3: Exactly one bit of `gate_row`, the bit for the current row, is high for the whole slot. A slot lasts Tsel+Tclr+Tset cycles. Rows follow one another as 0, 1, … N-1 with no gap between them.
- R4: `sample_sig` pulses for one cycle in slot cycle Tsel-1, which is the last cycle before the clear line rises. It pulses once per row.
- R5: The clear line of the current row, and only that line, is high in slot cycles Tsel through Tsel+Tclr-1. It is low again before the pedestal strobe.
- R6: `sample_ped` and `row_valid` pulse together in the last cycle of the slot, while `row_idx` shows the current row.
- R7: `frame_done` pulses for one cycle, together with the pedestal strobe of row N-1.
- R8: After row N-1, row 0 of the next frame starts in the following cycle. That frame uses the row count and phase lengths present on the inputs at the boundary. Input changes made during a frame do not alter that frame.
- R9: A `stop` pulse during a frame lets the frame complete. The block is then idle from the next cycle onward.
- R10: A phase length of 0 acts as 1. A row count of 0 acts as 1, and a row count above ROWS acts as ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame when idle |
| stop | input | 1 | Finish the current frame, then idle |
| num_rows | input | CNT_W | Rows per frame |
| t_select | input | DUR_W | Select settle length in cycles |
| t_clear | input | DUR_W | Clear pulse length in cycles |
| t_settle | input | DUR_W | Pedestal settle length in cycles |
| gate_row | output | ROWS | One-hot row select lines |
| clear_row | output | ROWS | One-hot row clear lines |
| sample_sig | output | 1 | Signal-plus-pedestal sample strobe |
| sample_ped | output | 1 | Pedestal sample strobe |
| row_valid | output | 1 | Row complete, `row_idx` valid |
| row_idx | output | ROW_W | Current row index |
| frame_done | output | 1 | Last row of the frame complete |

## Verification
The bench compares every output in every cycle of two consecutive frames for each stimulus vector, with the phase lengths set to their minimum of one cycle as well as to longer values. An off-by-one phase counter would move a strobe onto the clear edge or lengthen the slot. A clear that lingers would still be high at the pedestal strobe. Each vector changes the configuration part of the way through the first frame and pulses `start` again. A design that latched the inputs live would warp that frame, and one that restarted on the extra pulse would jump back to row 0. Zero and oversize counts test the clamping, and a `stop` pulse at the start of the second frame tests that the block neither stops early nor runs on.

// File: rtl/pixrow_pkg.sv
package pixrow_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SELECT = 2'd1,
        PH_CLEAR  = 2'd2,
        PH_SETTLE = 2'd3
    } phase_e;

    // Last counter value of a phase whose programmed length is v (0 acts as 1).
    function automatic int unsigned phase_end(int unsigned v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    // Effective row count: at least 1, at most max_rows.
    function automatic int unsigned fit_rows(int unsigned n, int unsigned max_rows);
        if (n == 0)        return 1;
        if (n > max_rows)  return max_rows;
        return n;
    endfunction

endpackage

// File: rtl/pixrow_cfg.sv
module pixrow_cfg
    import pixrow_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int DUR_W = 8,
    parameter int ROW_W = $clog2(ROWS),
    parameter int CNT_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] num_rows,
    input  logic [DUR_W-1:0] t_select,
    input  logic [DUR_W-1:0] t_clear,
    input  logic [DUR_W-1:0] t_settle,
    output logic [ROW_W-1:0] last_row,
    output logic [DUR_W-1:0] end_sel,
    output logic [DUR_W-1:0] end_clr,
    output logic [DUR_W-1:0] end_set
);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_row <= '0;
            end_sel  <= '0;
            end_clr  <= '0;
            end_set  <= '0;
        end else if (load) begin
            last_row <= ROW_W'(fit_rows(32'(num_rows), ROWS) - 1);
            end_sel  <= DUR_W'(phase_end(32'(t_select)));
            end_clr  <= DUR_W'(phase_end(32'(t_clear)));
            end_set  <= DUR_W'(phase_end(32'(t_settle)));
        end
    end

endmodule

// File: rtl/pixrow_fsm.sv
module pixrow_fsm
    import pixrow_pkg::*;
#(
    parameter int DUR_W = 8,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [ROW_W-1:0] last_row,
    input  logic [DUR_W-1:0] end_sel,
    input  logic [DUR_W-1:0] end_clr,
    input  logic [DUR_W-1:0] end_set,
    output phase_e           phase,
    output logic [ROW_W-1:0] row,
    output logic             at_end,
    output logic             load
);

    logic [DUR_W-1:0] cnt;
    logic [DUR_W-1:0] cur_end;
    logic             stop_req;
    logic             halt;
    logic             frame_end;

    always_comb begin
        unique case (phase)
            PH_SELECT: cur_end = end_sel;
            PH_CLEAR:  cur_end = end_clr;
            PH_SETTLE: cur_end = end_set;
            default:   cur_end = '0;
        endcase
        at_end    = (phase != PH_IDLE) && (cnt == cur_end);
        frame_end = (phase == PH_SETTLE) && at_end && (row == last_row);
        halt      = stop_req || stop;
        load      = ((phase == PH_IDLE) && start) || (frame_end && !halt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            row      <= '0;
            stop_req <= 1'b0;
        end else if (phase == PH_IDLE) begin
            stop_req <= 1'b0;
            cnt      <= '0;
            row      <= '0;
            if (start) phase <= PH_SELECT;
        end else begin
            if (stop) stop_req <= 1'b1;
            if (!at_end) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                unique case (phase)
                    PH_SELECT: phase <= PH_CLEAR;
                    PH_CLEAR:  phase <= PH_SETTLE;
                    default: begin
                        if (row != last_row) begin
                            row   <= row + 1'b1;
                            phase <= PH_SELECT;
                        end else begin
                            row      <= '0;
                            stop_req <= 1'b0;
                            phase    <= halt ? PH_IDLE : PH_SELECT;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pixrow_decode.sv
module pixrow_decode
    import pixrow_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int ROW_W = 4
) (
    input  phase_e           phase,
    input  logic [ROW_W-1:0] row,
    input  logic             at_end,
    input  logic [ROW_W-1:0] last_row,
    output logic [ROWS-1:0]  gate_row,
    output logic [ROWS-1:0]  clear_row,
    output logic             sample_sig,
    output logic             sample_ped,
    output logic             row_valid,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_done
);

    logic running;
    assign running = (phase != PH_IDLE);

    for (genvar i = 0; i < ROWS; i++) begin : g_line
        logic hit;
        assign hit          = running && (row == ROW_W'(i));
        assign gate_row[i]  = hit;
        assign clear_row[i] = hit && (phase == PH_CLEAR);
    end

    assign sample_sig = (phase == PH_SELECT) && at_end;
    assign sample_ped = (phase == PH_SETTLE) && at_end;
    assign row_valid  = sample_ped;
    assign row_idx    = row;
    assign frame_done = sample_ped && (row == last_row);

endmodule

// File: rtl/pixrow_seq.sv
module pixrow_seq
    import pixrow_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int DUR_W = 8,
    parameter int ROW_W = $clog2(ROWS),
    parameter int CNT_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] num_rows,
    input  logic [DUR_W-1:0] t_select,
    input  logic [DUR_W-1:0] t_clear,
    input  logic [DUR_W-1:0] t_settle,
    output logic [ROWS-1:0]  gate_row,
    output logic [ROWS-1:0]  clear_row,
    output logic             sample_sig,
    output logic             sample_ped,
    output logic             row_valid,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_done
);

    logic [ROW_W-1:0] last_row;
    logic [DUR_W-1:0] end_sel, end_clr, end_set;
    logic [ROW_W-1:0] row;
    logic             at_end;
    logic             load;
    phase_e           phase;

    pixrow_cfg #(.ROWS(ROWS), .DUR_W(DUR_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .load(load),
        .num_rows(num_rows), .t_select(t_select), .t_clear(t_clear), .t_settle(t_settle),
        .last_row(last_row), .end_sel(end_sel), .end_clr(end_clr), .end_set(end_set)
    );

    pixrow_fsm #(.DUR_W(DUR_W), .ROW_W(ROW_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .last_row(last_row), .end_sel(end_sel), .end_clr(end_clr), .end_set(end_set),
        .phase(phase), .row(row), .at_end(at_end), .load(load)
    );

    pixrow_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
        .phase(phase), .row(row), .at_end(at_end), .last_row(last_row),
        .gate_row(gate_row), .clear_row(clear_row),
        .sample_sig(sample_sig), .sample_ped(sample_ped),
        .row_valid(row_valid), .row_idx(row_idx), .frame_done(frame_done)
    );

endmodule

// File: rtl/pixrow_seq_chk.sv
module pixrow_seq_chk #(
    parameter int ROWS  = 16,
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [ROWS-1:0]  gate_row,
    input logic [ROWS-1:0]  clear_row,
    input logic             sample_sig,
    input logic             sample_ped,
    input logic             row_valid,
    input logic [ROW_W-1:0] row_idx,
    input logic             frame_done
);

    p_gate_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_row));

    p_clear_in_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (clear_row & ~gate_row) == '0);

    p_clear_low_at_ped_r5: assert property (@(posedge clk) disable iff (rst)
        sample_ped |-> clear_row == '0);

    p_sig_single_r4: assert property (@(posedge clk) disable iff (rst)
        sample_sig |=> !sample_sig);

    p_sig_before_clear_r4: assert property (@(posedge clk) disable iff (rst)
        sample_sig |=> $countones(clear_row) == 1);

    p_valid_with_ped_r6: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> sample_ped);

    p_done_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> row_valid);

    p_row_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (row_valid && !frame_done) |=> row_idx == $past(row_idx) + 1'b1);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (gate_row == '0) |-> (clear_row == '0 && !sample_sig && !sample_ped && row_idx == '0));

endmodule

bind pixrow_seq pixrow_seq_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .gate_row(gate_row), .clear_row(clear_row),
    .sample_sig(sample_sig), .sample_ped(sample_ped), .row_valid(row_valid),
    .row_idx(row_idx), .frame_done(frame_done)
);

// File: tb/sim_pixrow_seq.sv
module sim_pixrow_seq;

    localparam int ROWS  = 16;
    localparam int DUR_W = 8;
    localparam int ROW_W = 4;
    localparam int CNT_W = 5;
    localparam int NV    = 6;

    // {n1, tsel1, tclr1, tset1, n2, tsel2, tclr2, tset2}
    localparam int unsigned TAB [0:NV-1][0:7] = '{
        '{4, 2, 2, 2,   4, 2, 2, 2},
        '{3, 1, 1, 1,   2, 3, 1, 2},
        '{0, 0, 0, 0,   1, 1, 2, 1},
        '{16, 1, 1, 1,  20, 2, 1, 1},
        '{5, 3, 4, 5,   2, 0, 3, 0},
        '{2, 5, 1, 3,   3, 1, 1, 1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic [CNT_W-1:0] num_rows = '0;
    logic [DUR_W-1:0] t_select = '0, t_clear = '0, t_settle = '0;
    logic [ROWS-1:0]  gate_row, clear_row;
    logic             sample_sig, sample_ped, row_valid, frame_done;
    logic [ROW_W-1:0] row_idx;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    pixrow_seq #(.ROWS(ROWS), .DUR_W(DUR_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .num_rows(num_rows),
        .t_select(t_select), .t_clear(t_clear), .t_settle(t_settle),
        .gate_row(gate_row), .clear_row(clear_row), .sample_sig(sample_sig),
        .sample_ped(sample_ped), .row_valid(row_valid), .row_idx(row_idx),
        .frame_done(frame_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " gate_row"},  32'(gate_row),  32'd0);
        chk({tag, " clear_row"}, 32'(clear_row), 32'd0);
        chk({tag, " strobes"},   {28'd0, sample_sig, sample_ped, row_valid, frame_done}, 32'd0);
        chk({tag, " row_idx"},   32'(row_idx),   32'd0);
    endtask

    function automatic int eff(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int effn(input int unsigned n);
        if (n == 0) return 1;
        if (n > ROWS) return ROWS;
        return n;
    endfunction

    // Check one frame cycle by cycle; sampling happens at negedges.
    task automatic run_frame(input int v, input int fr);
        int b = (fr == 1) ? 0 : 4;
        int n  = effn(TAB[v][b]);
        int ts = eff(TAB[v][b+1]);
        int tc = eff(TAB[v][b+2]);
        int tp = eff(TAB[v][b+3]);
        int len = ts + tc + tp;
        int g = 0;
        string ctx;
        ctx = $sformatf("v%0d f%0d%s", v, fr, (fr == 2) ? " R8" : "");
        if (v == 2 || v == 3) ctx = {ctx, " R10"};
        for (int r = 0; r < n; r++) begin
            for (int c = 0; c < len; c++) begin
                logic [ROWS-1:0] eg;
                logic ep;
                eg = ROWS'(1) << r;
                ep = (c == len - 1);
                if (fr == 1 && g == 0) chk("R2 first row select", 32'(gate_row), 32'd1);
                chk({ctx, " R3 gate_row"}, 32'(gate_row), 32'(eg));
                chk({ctx, " R5 clear_row"}, 32'(clear_row),
                    (c >= ts && c < ts + tc) ? 32'(eg) : 32'd0);
                chk({ctx, " R4 sample_sig"}, 32'(sample_sig), 32'(c == ts - 1));
                chk({ctx, " R6 sample_ped"}, 32'(sample_ped), 32'(ep));
                chk({ctx, " R6 row_valid"},  32'(row_valid),  32'(ep));
                chk({ctx, " R6 row_idx"},    32'(row_idx),    32'(r));
                chk({ctx, " R7 frame_done"}, 32'(frame_done), 32'(ep && r == n - 1));
                // mid-frame stimulus: new config and a stray start in frame 1, stop in frame 2
                if (fr == 1 && g == 0) begin
                    num_rows = CNT_W'(TAB[v][4]);
                    t_select = DUR_W'(TAB[v][5]);
                    t_clear  = DUR_W'(TAB[v][6]);
                    t_settle = DUR_W'(TAB[v][7]);
                end
                if (fr == 1) start = (g == 1);
                if (fr == 2) stop = (g == 0);
                g++;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 under reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 after reset");

        for (int v = 0; v < NV; v++) begin
            num_rows = CNT_W'(TAB[v][0]);
            t_select = DUR_W'(TAB[v][1]);
            t_clear  = DUR_W'(TAB[v][2]);
            t_settle = DUR_W'(TAB[v][3]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            run_frame(v, 1);
            run_frame(v, 2);
            stop = 1'b0;
            for (int k = 0; k < 3; k++) begin
                chk_idle("R9 idle after stop");
                @(negedge clk);
            end
        end

        // Reset in the middle of a frame returns the block to idle.
        num_rows = 5'd4; t_select = 8'd2; t_clear = 8'd2; t_settle = 8'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 running before reset", 32'(gate_row), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R1 after mid-frame reset");
        @(negedge clk);
        chk_idle("R1 stays idle without start");

        // Stop pulse in the final cycle of a one-row frame.
        num_rows = 5'd1; t_select = 8'd1; t_clear = 8'd1; t_settle = 8'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 frame_done single row", 32'(frame_done), 32'd1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk_idle("R9 stop in last cycle");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule